// File: doc/BRIEF.md
# SMBus Alert Response Target

This block lets a device on a two-wire SMBus/I2C bus ask the host for service over a shared alert wire. A one-cycle pulse on the local request input makes the block pull the active-low, open-drain alert wire. The host sees the wire low and reads from the alert response address, 7-bit `0x0C`. Every target that is still pulling the alert wire acknowledges that read and sends back a response byte. The upper seven bits of the byte are the target's own address and the lowest bit is a fixed tail bit.

Several targets can answer the same read. Because the bus is wired-AND, they arbitrate bit by bit while they transmit. A target that sends a 1 but reads a 0 has lost. It stops driving SDA for the rest of the transfer, raises a collision flag and keeps its alert asserted, so it answers again on the host's next `0x0C` read. The lowest address always wins. A target that gets its whole byte out releases the alert wire and pulses a serviced output.

The block takes SCL and SDA as raw samples and passes them through flop synchronisers. START and STOP are detected from the synchronised copies. All outputs are registered. Ordinary register transfers to the device's own address are handled elsewhere. Clock stretching, packet error checking and timeouts are also outside this block.

Top module: `smbus_alert_responder`

## Requirements
- R1: After reset, `sda_oe_o`, `alert_oe_o`, `coll_o` and `serviced_o` are all 0.
- R2: When `alert_req_i` pulses while the bus is idle (between a STOP and the next START), `alert_oe_o` goes to 1 within three clocks. It stays at 1 until the alert is serviced.
- R3: While `alert_oe_o` is 1, the block acknowledges an address byte of `0x19` (7-bit `0x0C` with the read bit 1) by pulling SDA low through the ninth SCL pulse. It does not acknowledge `0x18` (the same address with the write bit 0).
- R4: While `alert_oe_o` is 0, an address byte of `0x19` gets no acknowledge, and `sda_oe_o` stays 0 for the whole transfer.
- R5: After the acknowledge, the block sends `{dev_addr_i, TAIL_BIT}` most significant bit first. `sda_oe_o` rises only while the synchronised SCL is low.
- R6: When the block sends a 1 and samples SDA low during SCL high, it loses arbitration. It then sets `coll_o` and leaves `sda_oe_o` at 0 until the next START, so the byte seen on the bus is the winner's byte.
- R7: After losing arbitration, the block keeps `alert_oe_o` at 1 and answers the next `0x0C` read again.
- R8: When all eight bits of the response go out without a loss, `serviced_o` pulses for exactly one clock. `alert_oe_o` drops to 0 before the host's acknowledge bit, and `coll_o` stays 0.
- R9: A one-cycle pulse on `coll_clr_i` clears `coll_o`. If the pulse falls in the same clock as a new arbitration loss, the loss wins and `coll_o` ends at 1.
- R10: Any START, including a repeated START, clears `coll_o`.
- R11: If `alert_req_i` pulses while the bus is busy, the request is held. The block asserts `alert_oe_o` after the next STOP, even when the current transfer has just serviced the previous alert.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which oversamples SCL and SDA |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Raw sample of the SCL wire |
| sda_i | input | 1 | Raw sample of the SDA wire |
| alert_req_i | input | 1 | One-cycle pulse that requests host service |
| dev_addr_i | input | ADDR_W | This target's own bus address |
| coll_clr_i | input | 1 | Write-one-to-clear strobe for the collision flag |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| alert_oe_o | output | 1 | 1 pulls the alert wire low; 0 releases it |
| coll_o | output | 1 | Collision flag: arbitration was lost during the response |
| serviced_o | output | 1 | One-cycle pulse when the response byte went out in full |

## Verification
Two things can land on the same clock edge: software clearing the collision flag, and the block detecting a new arbitration loss. The bench sets this up with a competing target whose address is lower. It counts the synchroniser and edge-detect registers so that the one-cycle `coll_clr_i` pulse lands exactly in the cycle the design sees the SCL rise of the losing bit. It then requires `coll_o` to read 1. A second, calmer overlap is a local request that arrives in the middle of the byte that services the previous alert. The bench expects the alert wire to be released after the byte and pulled again only after STOP.

// File: rtl/sar_pkg.sv
package sar_pkg;

  // 7-bit address that the host reads to find the alerting target
  localparam logic [6:0] RESP_ADDR7 = 7'h0C;

  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for START
    ST_ADDR,   // shifting in the address byte
    ST_ACK,    // pulling the acknowledge bit low
    ST_TX,     // sending the response byte with arbitration
    ST_MACK,   // host acknowledge slot, bus released
    ST_SKIP    // not involved until the next START or STOP
  } sar_state_e;

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] q_prev_o
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [WIDTH-1:0]             prev_q;

  // Idle bus lines read high, so every stage resets to ones
  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= '1;
      prev_q  <= '1;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      prev_q <= chain_q[STAGES-1];
    end
  end

  assign q_o      = chain_q[STAGES-1];
  assign q_prev_o = prev_q;

endmodule

// File: rtl/sar_cond_det.sv
module sar_cond_det (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  input  logic scl_p,
  input  logic sda_p,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);

  always_comb begin
    scl_rise_o = scl_s & ~scl_p;
    scl_fall_o = ~scl_s & scl_p;
    // data edges count as bus conditions only while the clock stays high
    start_o    = scl_s & scl_p & sda_p & ~sda_s;
    stop_o     = scl_s & scl_p & ~sda_p & sda_s;
  end

  AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(start_o && stop_o)); // R10

  AST_COND_SCL_STEADY: assert property (@(posedge clk) disable iff (rst)
    (start_o || stop_o) |-> !(scl_rise_o || scl_fall_o)); // R10

endmodule

// File: rtl/sar_alert_ctl.sv
module sar_alert_ctl (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic bus_busy_i,
  input  logic serviced_i,
  output logic alert_o
);

  logic alert_q;
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      alert_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      if (serviced_i) alert_q <= 1'b0;
      if (req_i) begin
        if (bus_busy_i) pend_q  <= 1'b1;
        else            alert_q <= 1'b1;
      end
      if (!bus_busy_i && pend_q) begin
        alert_q <= 1'b1;
        pend_q  <= 1'b0;
      end
    end
  end

  assign alert_o = alert_q;

  AST_SVC_RELEASES: assert property (@(posedge clk) disable iff (rst)
    serviced_i |=> !alert_q); // R8

  AST_ALERT_RISE_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(alert_q) |-> $past(!bus_busy_i)); // R11

  AST_REQ_IDLE_TAKES: assert property (@(posedge clk) disable iff (rst)
    (req_i && !bus_busy_i) |=> alert_q); // R2

endmodule

// File: rtl/smbus_alert_responder.sv
module smbus_alert_responder #(
  parameter int   ADDR_W      = 7,
  parameter int   SYNC_STAGES = 2,
  parameter logic TAIL_BIT    = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              alert_req_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic              coll_clr_i,
  output logic              sda_oe_o,
  output logic              alert_oe_o,
  output logic              coll_o,
  output logic              serviced_o
);
  import sar_pkg::*;

  localparam int                BYTE_W    = ADDR_W + 1;
  localparam int                CNT_W     = $clog2(BYTE_W + 1);
  localparam logic [ADDR_W-1:0] RESP_ADDR = ADDR_W'(RESP_ADDR7);

  logic [1:0] line_s, line_p;
  logic       scl_s, sda_s;
  logic       start_c, stop_c, scl_rise, scl_fall;
  logic       alert_on;

  sar_state_e         state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [BYTE_W-1:0]  rx_q;
  logic [BYTE_W-1:0]  tx_q;
  logic               sda_oe_q;
  logic               coll_q;
  logic               svc_q;
  logic               busy_q;

  sar_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) sync_i (
    .clk      (clk),
    .rst      (rst),
    .d_i      ({scl_i, sda_i}),
    .q_o      (line_s),
    .q_prev_o (line_p)
  );

  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  sar_cond_det cond_i (
    .clk        (clk),
    .rst        (rst),
    .scl_s      (line_s[1]),
    .sda_s      (line_s[0]),
    .scl_p      (line_p[1]),
    .sda_p      (line_p[0]),
    .start_o    (start_c),
    .stop_o     (stop_c),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall)
  );

  sar_alert_ctl alert_i (
    .clk        (clk),
    .rst        (rst),
    .req_i      (alert_req_i),
    .bus_busy_i (busy_q),
    .serviced_i (svc_q),
    .alert_o    (alert_on)
  );

  always_ff @(posedge clk) begin
    if (rst) busy_q <= 1'b0;
    else if (start_c) busy_q <= 1'b1;
    else if (stop_c) busy_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      sda_oe_q <= 1'b0;
      coll_q   <= 1'b0;
      svc_q    <= 1'b0;
    end else begin
      svc_q <= 1'b0;
      // software clear first, so a loss in the same clock overrides it
      if (coll_clr_i) coll_q <= 1'b0;

      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            rx_q  <= {rx_q[BYTE_W-2:0], sda_s};
            cnt_q <= cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_W'(BYTE_W)) begin
            if (rx_q[BYTE_W-1:1] == RESP_ADDR && rx_q[0] && alert_on) begin
              state_q  <= ST_ACK;
              sda_oe_q <= 1'b1;
              tx_q     <= {dev_addr_i, TAIL_BIT};
            end else begin
              state_q  <= ST_SKIP;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            state_q  <= ST_TX;
            cnt_q    <= '0;
            sda_oe_q <= ~tx_q[BYTE_W-1];
          end
        end
        ST_TX: begin
          if (scl_rise && tx_q[BYTE_W-1] && !sda_s) begin
            coll_q  <= 1'b1;
            state_q <= ST_SKIP;
          end else if (scl_fall) begin
            if (cnt_q == CNT_W'(BYTE_W - 1)) begin
              state_q  <= ST_MACK;
              sda_oe_q <= 1'b0;
              svc_q    <= 1'b1;
            end else begin
              cnt_q    <= cnt_q + 1'b1;
              tx_q     <= {tx_q[BYTE_W-2:0], 1'b0};
              sda_oe_q <= ~tx_q[BYTE_W-2];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) state_q <= ST_SKIP;
        end
        default: ;
      endcase

      if (start_c) begin
        state_q  <= ST_ADDR;
        cnt_q    <= '0;
        sda_oe_q <= 1'b0;
        coll_q   <= 1'b0;
      end else if (stop_c) begin
        state_q  <= ST_IDLE;
        sda_oe_q <= 1'b0;
      end
    end
  end

  assign sda_oe_o   = sda_oe_q;
  assign alert_oe_o = alert_on;
  assign coll_o     = coll_q;
  assign serviced_o = svc_q;

  AST_DRIVE_NEEDS_ALERT: assert property (@(posedge clk) disable iff (rst)
    sda_oe_q |-> alert_on); // R4

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_q) |-> !scl_s); // R5

  AST_LOSER_SILENT: assert property (@(posedge clk) disable iff (rst)
    coll_q |-> !sda_oe_q); // R6

  AST_SVC_SINGLE: assert property (@(posedge clk) disable iff (rst)
    svc_q |=> !svc_q); // R8

  AST_START_CLEARS_COLL: assert property (@(posedge clk) disable iff (rst)
    start_c |=> !coll_q); // R10

endmodule

// File: tb/smbus_alert_responder_tb_top.sv
module smbus_alert_responder_tb_top;

  localparam int Q = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       m_low = 1'b0;
  logic       c_low = 1'b0;
  logic       alert_req = 1'b0;
  logic       coll_clr = 1'b0;
  logic [6:0] dev_addr = 7'h56;
  logic       sda_oe, alert_oe, coll, serviced;
  logic       sda_line;

  int n_tot = 0;
  int n_bad = 0;
  int svc_cnt = 0;
  bit dut_drove = 1'b0;
  bit bad_edge = 1'b0;
  bit prev_oe = 1'b0;
  bit done = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] obs_byte;
  event       got_ev;

  always #2.5 clk = ~clk;

  assign sda_line = ~(sda_oe | m_low | c_low);

  smbus_alert_responder dut_i (
    .clk         (clk),
    .rst         (rst),
    .scl_i       (scl),
    .sda_i       (sda_line),
    .alert_req_i (alert_req),
    .dev_addr_i  (dev_addr),
    .coll_clr_i  (coll_clr),
    .sda_oe_o    (sda_oe),
    .alert_oe_o  (alert_oe),
    .coll_o      (coll),
    .serviced_o  (serviced)
  );

  always @(posedge clk) begin
    if (serviced) svc_cnt <= svc_cnt + 1;
    if (sda_oe) dut_drove <= 1'b1;
    if (!rst && sda_oe && !prev_oe && scl) bad_edge <= 1'b1;
    prev_oe <= sda_oe;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_tot, n_bad);
      $finish;
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(got_ev);
      if (exp_q.size() == 0) check("scoreboard empty", 1, 0);
      else check(tag_q.pop_front(), {24'h0, obs_byte}, {24'h0, exp_q.pop_front()});
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    m_low = 1'b0; scl = 1'b1; wait_n(Q);
    m_low = 1'b1; wait_n(Q);
    scl = 1'b0; wait_n(Q);
  endtask

  task automatic do_rstart();
    m_low = 1'b0; wait_n(Q);
    scl = 1'b1; wait_n(Q);
    m_low = 1'b1; wait_n(Q);
    scl = 1'b0; wait_n(Q);
  endtask

  task automatic do_stop();
    m_low = 1'b1; wait_n(Q);
    scl = 1'b1; wait_n(Q);
    m_low = 1'b0; wait_n(2*Q);
  endtask

  task automatic put_bit(bit b);
    m_low = !b; wait_n(Q);
    scl = 1'b1; wait_n(2*Q);
    scl = 1'b0; wait_n(Q);
  endtask

  task automatic get_bit(bit cb, bit c_on, bit clr_hit, output bit b);
    m_low = 1'b0;
    c_low = c_on && !cb;
    wait_n(Q);
    scl = 1'b1;
    if (clr_hit) begin
      // two synchroniser stages then the edge register: the design acts on the third edge
      @(posedge clk); @(posedge clk);
      @(negedge clk); coll_clr = 1'b1;
      @(negedge clk); coll_clr = 1'b0;
      wait_n(Q - 2);
    end else begin
      wait_n(Q);
    end
    b = sda_line;
    wait_n(Q);
    scl = 1'b0; wait_n(Q);
  endtask

  task automatic ara_read(logic [7:0] addr_byte, logic [7:0] comp_byte, bit comp_on,
                          bit clr_hit, bit req_mid, output bit ack);
    bit         b;
    bit         alive;
    logic [7:0] got;
    do_start();
    for (int i = 7; i >= 0; i--) put_bit(addr_byte[i]);
    m_low = 1'b0; c_low = comp_on; wait_n(Q);
    scl = 1'b1; wait_n(Q);
    ack = sda_line; wait_n(Q);
    scl = 1'b0; wait_n(Q);
    c_low = 1'b0;
    if (ack == 1'b0) begin
      alive = comp_on;
      got = '0;
      for (int i = 7; i >= 0; i--) begin
        get_bit(comp_byte[i], alive, clr_hit && i == 7, b);
        if (alive && comp_byte[i] && !b) alive = 1'b0;
        got[i] = b;
        if (req_mid && i == 4) begin
          alert_req = 1'b1; @(negedge clk); alert_req = 1'b0;
        end
      end
      c_low = 1'b0;
      put_bit(1'b1);
      obs_byte = got;
      -> got_ev;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tot++; n_bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    finish_run();
  end

  initial begin
    bit ack;
    int s0;
    wait_n(6);
    rst = 1'b0;
    wait_n(2);
    // R1
    check("R1 sda_oe", sda_oe, 0);
    check("R1 alert_oe", alert_oe, 0);
    check("R1 coll", coll, 0);
    check("R1 serviced", serviced, 0);

    // R4: no alert, 0x0C read is ignored
    dut_drove = 1'b0;
    ara_read(8'h19, 8'h00, 1'b0, 1'b0, 1'b0, ack);
    check("R4 nack", ack, 1);
    check("R4 no drive", dut_drove, 0);
    do_stop();

    // R2
    alert_req = 1'b1; @(negedge clk); alert_req = 1'b0;
    wait_n(3);
    check("R2 alert asserted", alert_oe, 1);

    // R3: write direction is not acknowledged
    ara_read(8'h18, 8'h00, 1'b0, 1'b0, 1'b0, ack);
    check("R3 write nack", ack, 1);
    do_stop();
    check("R2 alert held", alert_oe, 1);

    // R6: lower competitor 0x34 beats 0x56
    s0 = svc_cnt;
    exp_q.push_back(8'h68); tag_q.push_back("R6 bus byte is winner");
    ara_read(8'h19, 8'h68, 1'b1, 1'b0, 1'b0, ack);
    check("R3 read ack", ack, 0);
    check("R6 coll set", coll, 1);
    check("R6 no service", svc_cnt - s0, 0);
    check("R7 alert kept", alert_oe, 1);

    // R10: repeated START clears the flag
    do_rstart();
    wait_n(2);
    check("R10 rstart clears", coll, 0);
    do_stop();

    // R7 / R8: alone on the retry, the block wins
    s0 = svc_cnt;
    exp_q.push_back(8'hAC); tag_q.push_back("R5 own response byte");
    ara_read(8'h19, 8'h00, 1'b0, 1'b0, 1'b0, ack);
    check("R7 retry ack", ack, 0);
    check("R8 one service pulse", svc_cnt - s0, 1);
    check("R8 alert released", alert_oe, 0);
    check("R8 coll clear", coll, 0);
    do_stop();

    // R9: software clear
    alert_req = 1'b1; @(negedge clk); alert_req = 1'b0;
    wait_n(3);
    exp_q.push_back(8'h68); tag_q.push_back("R6 loser byte again");
    ara_read(8'h19, 8'h68, 1'b1, 1'b0, 1'b0, ack);
    check("R6 coll before clear", coll, 1);
    coll_clr = 1'b1; @(negedge clk); coll_clr = 1'b0;
    wait_n(1);
    check("R9 sw clear", coll, 0);
    do_stop();

    // R9: clear and loss in the same clock, loss wins
    exp_q.push_back(8'h68); tag_q.push_back("R6 loser byte same-cycle");
    ara_read(8'h19, 8'h68, 1'b1, 1'b1, 1'b0, ack);
    check("R9 set beats clear", coll, 1);
    do_stop();

    // R11: request mid-transfer after the alert is serviced
    exp_q.push_back(8'hAC); tag_q.push_back("R5 byte with late request");
    ara_read(8'h19, 8'h00, 1'b0, 1'b0, 1'b1, ack);
    check("R11 released after byte", alert_oe, 0);
    do_stop();
    wait_n(3);
    check("R11 reasserted after stop", alert_oe, 1);

    // R8: block with lower address beats a higher competitor
    dev_addr = 7'h12;
    s0 = svc_cnt;
    exp_q.push_back(8'h24); tag_q.push_back("R8 winner byte");
    ara_read(8'h19, 8'h68, 1'b1, 1'b0, 1'b0, ack);
    check("R8 win no coll", coll, 0);
    check("R8 win serviced", svc_cnt - s0, 1);
    check("R8 win released", alert_oe, 0);
    do_stop();

    check("R5 sda only moves with scl low", bad_edge, 0);
    wait_n(4);
    check("R5 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end

endmodule